// File: doc/BRIEF.md
# Ethernet Buffer-Descriptor Ring Engine

This block moves frames between memory and the packet datapath of an Ethernet MAC. It keeps two rings of descriptors in memory, one for receive and one for transmit. Each descriptor is two 32-bit words on an 8-byte boundary: a status word first, then a buffer address. Software writes a ring's base address through a pointer strobe and then pulses that ring's enable. The engine reads the current descriptor. If the descriptor's ownership bit is set, the engine moves the frame. It then writes the status back with the ownership bit cleared, and moves to the next descriptor. A descriptor whose wrap bit is set sends the engine back to the ring base.

The packet side is a plain byte stream with valid/ready handshakes. Buffer words are little-endian, so byte 0 of a frame sits in bits 7:0 of the first buffer word, and buffers must be word aligned. Both engines share a single request/acknowledge memory port. When an engine reaches a descriptor that software has not yet handed over, it clears its own enable and stops there. Software re-arms the descriptor and pulses the enable again to resume. While receive is disabled, incoming bytes are accepted and discarded.

Top module: `bd_ring_dma`

## Requirements
- R1: After reset both enables are 0, both pointers are 0, and mem_req, tx_valid and mem_we are 0.
- R2: A pointer write loads both the ring base and the current descriptor pointer with the written value, with bits 2:0 forced to 0.
- R3: The transmit engine streams exactly LEN bytes (status bits 10:0) from the buffer in little-endian order. tx_last is set on the final byte only, and tx_data/tx_last are held while tx_ready is low.
- R4: Transmit writeback keeps LEN and the wrap bit (bit 12), clears the ownership bit (bit 11), and reports tx_err sampled with the last byte: bit 0 late collision in bit 13, bit 1 underrun in bit 14, bit 2 attempt limit in bit 15.
- R5: The receive engine packs bytes into consecutive buffer words, little-endian, with unused upper lanes of the final word written as 0. It writes the stored byte count into bits 10:0.
- R6: Receive writeback reports rx_err sampled with rx_last: bit 0 alignment in bit 14, bit 1 overrun in bit 15, bit 2 CRC in bit 16. It clears bit 11 and keeps bit 12.
- R7: Receive bytes beyond MAX_FRAME are consumed but not stored. The length field is then MAX_FRAME and bit 13 (frame too long) is set.
- R8: After a descriptor with the wrap bit is finished, the pointer returns to the ring base. Otherwise it advances by 8.
- R9: A fetched status word with bit 11 clear makes the engine clear its enable and stop with the pointer on that descriptor. A later enable pulse resumes from the same descriptor.
- R10: While receive is disabled, rx_ready is 1 and bytes are discarded with no memory write. A frame already in progress when the enable is set is discarded whole.
- R11: For each frame the status write is the last memory write, after every buffer data write.
- R12: A single transmit descriptor with the wrap bit loops back to itself.
- R13: The memory request holds its address, direction and data until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ptr_wr | input | 1 | Load receive ring base and pointer |
| tx_ptr_wr | input | 1 | Load transmit ring base and pointer |
| ptr_wdata | input | 32 | Pointer value for the loads |
| rx_en_set | input | 1 | Pulse: set receive enable |
| tx_en_set | input | 1 | Pulse: set transmit enable |
| rx_en | output | 1 | Receive enable state |
| tx_en | output | 1 | Transmit enable state |
| rx_ptr | output | 32 | Current receive descriptor address |
| tx_ptr | output | 32 | Current transmit descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 3 | Receive error flags, valid with rx_last |
| rx_ready | output | 1 | Receive byte accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Transmit byte taken |
| tx_err | input | 3 | Transmit error flags, valid with the last byte |

## Verification
The bench covers several failure modes:
- A two-entry ring is walked to its wrap and then stopped on the re-fetched first descriptor. A design that ignored the wrap bit would run past the ring, and one that advanced on a stop would leave the pointer on the wrong entry.
- An oversized frame checks that bytes past the limit never reach memory and that the length saturates. Without this, the word after the buffer is overwritten.
- A frame that starts while receive is disabled and continues after the enable pulse must vanish entirely. A design that resynchronised mid-frame would store a truncated tail.
- Transmit under intermittent tx_ready, with error flags, checks byte order, the single last marker and the error bit positions.
- Write ordering is logged, so that a status written before its data shows up.

// File: rtl/bd_ring_pkg.sv
// Package: shared status-word layout and engine state encodings for the
// descriptor ring engine. Assumes a 32-bit status word per descriptor.
package bd_ring_pkg;
    localparam int ST_LEN_W   = 11;  // length field width, bits 10:0
    localparam int EN_BIT     = 11;  // ownership: 1 = hardware may use it
    localparam int WRAP_BIT   = 12;  // last descriptor of the ring
    localparam int RXE_LONG   = 13;
    localparam int RXE_ALIGN  = 14;
    localparam int RXE_OVR    = 15;
    localparam int RXE_CRC    = 16;
    localparam int TXE_LATE   = 13;
    localparam int TXE_UNDER  = 14;
    localparam int TXE_LIMIT  = 15;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        R_IDLE, R_FETCH_ST, R_FETCH_AD, R_RECV, R_WDATA, R_WSTAT
    } rx_state_t;

    typedef enum logic [2:0] {
        T_IDLE, T_FETCH_ST, T_FETCH_AD, T_RDATA, T_SEND, T_WSTAT
    } tx_state_t;
endpackage

// File: rtl/bd_ring_arb.sv
// Two-way arbiter for the shared memory port. Port A (receive) wins when
// both ask in the same idle cycle. Once a request is issued, the grant is
// locked to its owner until mem_ack. Assumes each requester holds its
// request stable until acknowledged.
module bd_ring_arb (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_req,
    input  logic        a_we,
    input  logic [31:0] a_addr,
    input  logic [31:0] a_wdata,
    output logic        a_ack,
    input  logic        b_req,
    input  logic        b_we,
    input  logic [31:0] b_addr,
    input  logic [31:0] b_wdata,
    output logic        b_ack,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack
);
    logic busy_q;
    logic own_b_q;
    logic pick_b;

    // Select the owner: locked while busy, else A has priority.
    always_comb begin
        pick_b    = busy_q ? own_b_q : !a_req;
        mem_req   = pick_b ? b_req   : a_req;
        mem_we    = pick_b ? b_we    : a_we;
        mem_addr  = pick_b ? b_addr  : a_addr;
        mem_wdata = pick_b ? b_wdata : a_wdata;
        a_ack     = mem_ack && !pick_b;
        b_ack     = mem_ack && pick_b;
    end

    // Track an outstanding request and its owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            own_b_q <= 1'b0;
        end else if (mem_ack) begin
            busy_q  <= 1'b0;
        end else if (mem_req) begin
            busy_q  <= 1'b1;
            own_b_q <= pick_b;
        end
    end

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/bd_ring_rx.sv
// Receive descriptor engine. Fetches the status and buffer words of the
// current descriptor, packs incoming bytes little-endian into buffer
// words, then writes the status back as the frame's last memory write.
// Assumes word-aligned buffers and MAX_FRAME below 2^ST_LEN_W.
module bd_ring_rx
    import bd_ring_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_wr,
    input  logic [31:0] ptr_wdata,
    input  logic        en_set,
    output logic        en,
    output logic [31:0] ptr_cur,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic [2:0]  rx_err,
    output logic        rx_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int OFF_W = ST_LEN_W + 2;
    localparam logic [ST_LEN_W-1:0] CAP = ST_LEN_W'(MAX_FRAME);

    rx_state_t            state_q;
    logic                 en_q;
    logic [31:0]          base_q, cur_q, buf_q;
    logic                 wrap_q;
    logic [OFF_W-1:0]     off_q;
    logic [ST_LEN_W-1:0]  cnt_q;
    logic [1:0]           lane_q;
    logic [31:0]          word_q;
    logic                 pend_q, started_q, mid_q, long_q, done_q;
    logic [2:0]           err_q;
    logic [31:0]          status_w;
    logic                 accept, store;

    // Status word written back: length, wrap kept, ownership cleared.
    always_comb begin
        status_w                = '0;
        status_w[ST_LEN_W-1:0]  = cnt_q;
        status_w[WRAP_BIT]      = wrap_q;
        status_w[RXE_LONG]      = long_q;
        status_w[RXE_ALIGN]     = err_q[0];
        status_w[RXE_OVR]       = err_q[1];
        status_w[RXE_CRC]       = err_q[2];
    end

    // Memory request and byte-side handshake decode.
    always_comb begin
        rx_ready  = (state_q == R_RECV) || (state_q == R_IDLE && !en_q);
        accept    = rx_valid && rx_ready;
        store     = cnt_q < CAP;
        mem_req   = (state_q == R_FETCH_ST) || (state_q == R_FETCH_AD) ||
                    (state_q == R_WDATA)    || (state_q == R_WSTAT);
        mem_we    = (state_q == R_WDATA) || (state_q == R_WSTAT);
        mem_wdata = (state_q == R_WDATA) ? word_q : status_w;
        case (state_q)
            R_FETCH_AD: mem_addr = cur_q + 32'd4;
            R_WDATA:    mem_addr = buf_q + {{(32-OFF_W){1'b0}}, off_q};
            default:    mem_addr = cur_q;
        endcase
    end

    // Frame-boundary tracker: set while a frame is part way through.
    always_ff @(posedge clk) begin
        if (!rst_n)       mid_q <= 1'b0;
        else if (accept)  mid_q <= !rx_last;
    end

    // Main receive state machine and its datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;  en_q <= 1'b0;
            base_q <= '0;  cur_q <= '0;  buf_q <= '0;  wrap_q <= 1'b0;
            off_q <= '0;  cnt_q <= '0;  lane_q <= '0;  word_q <= '0;
            pend_q <= 1'b0;  started_q <= 1'b0;  long_q <= 1'b0;
            done_q <= 1'b0;  err_q <= '0;
        end else begin
            case (state_q)
                R_IDLE: if (en_q) begin
                    state_q <= R_FETCH_ST;
                    off_q <= '0;  cnt_q <= '0;  lane_q <= '0;  word_q <= '0;
                    pend_q <= 1'b0;  started_q <= 1'b0;  long_q <= 1'b0;
                    done_q <= 1'b0;  err_q <= '0;
                end
                R_FETCH_ST: if (mem_ack) begin
                    if (!mem_rdata[EN_BIT]) begin
                        en_q    <= 1'b0;
                        state_q <= R_IDLE;
                    end else begin
                        wrap_q  <= mem_rdata[WRAP_BIT];
                        state_q <= R_FETCH_AD;
                    end
                end
                R_FETCH_AD: if (mem_ack) begin
                    buf_q   <= mem_rdata;
                    state_q <= R_RECV;
                end
                R_RECV: if (rx_valid && !(!started_q && mid_q)) begin
                    started_q <= 1'b1;
                    if (store) begin
                        word_q[{lane_q, 3'b000} +: 8] <= rx_data;
                        lane_q <= lane_q + 2'd1;
                        cnt_q  <= cnt_q + ST_LEN_W'(1);
                        pend_q <= 1'b1;
                    end else begin
                        long_q <= 1'b1;
                    end
                    if (rx_last) begin
                        err_q   <= rx_err;
                        done_q  <= 1'b1;
                        state_q <= (store || pend_q) ? R_WDATA : R_WSTAT;
                    end else if (store && lane_q == 2'd3) begin
                        state_q <= R_WDATA;
                    end
                end
                R_WDATA: if (mem_ack) begin
                    off_q   <= off_q + OFF_W'(4);
                    word_q  <= '0;
                    lane_q  <= '0;
                    pend_q  <= 1'b0;
                    state_q <= done_q ? R_WSTAT : R_RECV;
                end
                R_WSTAT: if (mem_ack) begin
                    cur_q   <= wrap_q ? base_q : cur_q + 32'(DESC_BYTES);
                    state_q <= R_IDLE;
                end
                default: state_q <= R_IDLE;
            endcase
            if (ptr_wr) begin
                base_q <= ptr_wdata & 32'hFFFF_FFF8;
                cur_q  <= ptr_wdata & 32'hFFFF_FFF8;
            end
            if (en_set) en_q <= 1'b1;
        end
    end

    assign en      = en_q;
    assign ptr_cur = cur_q;

    p_wrap_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_WSTAT && mem_ack && wrap_q && !ptr_wr) |=> (cur_q == base_q));
    p_stop_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_FETCH_ST && mem_ack && !mem_rdata[EN_BIT] && !en_set)
        |=> (!en_q && state_q == R_IDLE));
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && state_q == R_IDLE) |-> (rx_ready && !mem_req));
    p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);
    p_stat_after_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_WSTAT) |-> !pend_q);
endmodule

// File: rtl/bd_ring_tx.sv
// Transmit descriptor engine. Fetches the current descriptor, reads the
// buffer one word at a time, streams LEN bytes little-endian and then
// writes back the status with the ownership bit cleared. Assumes
// word-aligned buffers.
module bd_ring_tx
    import bd_ring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_wr,
    input  logic [31:0] ptr_wdata,
    input  logic        en_set,
    output logic        en,
    output logic [31:0] ptr_cur,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic [2:0]  tx_err,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int OFF_W = ST_LEN_W + 2;

    tx_state_t            state_q;
    logic                 en_q;
    logic [31:0]          base_q, cur_q, buf_q;
    logic                 wrap_q;
    logic [ST_LEN_W-1:0]  len_q, sent_q;
    logic [OFF_W-1:0]     off_q;
    logic [1:0]           lane_q;
    logic [31:0]          word_q;
    logic [2:0]           err_q;
    logic [31:0]          status_w;

    // Writeback status: length and wrap kept, ownership cleared, errors.
    always_comb begin
        status_w                = '0;
        status_w[ST_LEN_W-1:0]  = len_q;
        status_w[WRAP_BIT]      = wrap_q;
        status_w[TXE_LATE]      = err_q[0];
        status_w[TXE_UNDER]     = err_q[1];
        status_w[TXE_LIMIT]     = err_q[2];
    end

    // Byte stream and memory request decode.
    always_comb begin
        tx_valid  = (state_q == T_SEND);
        tx_data   = word_q[{lane_q, 3'b000} +: 8];
        tx_last   = tx_valid && ((sent_q + ST_LEN_W'(1)) == len_q);
        mem_req   = (state_q == T_FETCH_ST) || (state_q == T_FETCH_AD) ||
                    (state_q == T_RDATA)    || (state_q == T_WSTAT);
        mem_we    = (state_q == T_WSTAT);
        mem_wdata = status_w;
        case (state_q)
            T_FETCH_AD: mem_addr = cur_q + 32'd4;
            T_RDATA:    mem_addr = buf_q + {{(32-OFF_W){1'b0}}, off_q};
            default:    mem_addr = cur_q;
        endcase
    end

    // Main transmit state machine and its datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;  en_q <= 1'b0;
            base_q <= '0;  cur_q <= '0;  buf_q <= '0;  wrap_q <= 1'b0;
            len_q <= '0;  sent_q <= '0;  off_q <= '0;  lane_q <= '0;
            word_q <= '0;  err_q <= '0;
        end else begin
            case (state_q)
                T_IDLE: if (en_q) begin
                    state_q <= T_FETCH_ST;
                    sent_q <= '0;  off_q <= '0;  lane_q <= '0;  err_q <= '0;
                end
                T_FETCH_ST: if (mem_ack) begin
                    if (!mem_rdata[EN_BIT]) begin
                        en_q    <= 1'b0;
                        state_q <= T_IDLE;
                    end else begin
                        len_q   <= mem_rdata[ST_LEN_W-1:0];
                        wrap_q  <= mem_rdata[WRAP_BIT];
                        state_q <= T_FETCH_AD;
                    end
                end
                T_FETCH_AD: if (mem_ack) begin
                    buf_q   <= mem_rdata;
                    state_q <= (len_q == '0) ? T_WSTAT : T_RDATA;
                end
                T_RDATA: if (mem_ack) begin
                    word_q  <= mem_rdata;
                    off_q   <= off_q + OFF_W'(4);
                    state_q <= T_SEND;
                end
                T_SEND: if (tx_ready) begin
                    sent_q <= sent_q + ST_LEN_W'(1);
                    lane_q <= lane_q + 2'd1;
                    if (tx_last) begin
                        err_q   <= tx_err;
                        state_q <= T_WSTAT;
                    end else if (lane_q == 2'd3) begin
                        state_q <= T_RDATA;
                    end
                end
                T_WSTAT: if (mem_ack) begin
                    cur_q   <= wrap_q ? base_q : cur_q + 32'(DESC_BYTES);
                    state_q <= T_IDLE;
                end
                default: state_q <= T_IDLE;
            endcase
            if (ptr_wr) begin
                base_q <= ptr_wdata & 32'hFFFF_FFF8;
                cur_q  <= ptr_wdata & 32'hFFFF_FFF8;
            end
            if (en_set) en_q <= 1'b1;
        end
    end

    assign en      = en_q;
    assign ptr_cur = cur_q;

    p_byte_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    p_tx_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_FETCH_ST && mem_ack && !mem_rdata[EN_BIT] && !en_set) |=> !en_q);
    p_tx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_WSTAT && mem_ack && wrap_q && !ptr_wr) |=> (cur_q == base_q));
endmodule

// File: rtl/bd_ring_dma.sv
// Top of the descriptor ring engine: one receive engine, one transmit
// engine and an arbiter onto the single memory port. Assumes the memory
// holds mem_ack low until it can complete the request on the port.
module bd_ring_dma #(
    parameter int MAX_FRAME = 1518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_ptr_wr,
    input  logic        tx_ptr_wr,
    input  logic [31:0] ptr_wdata,
    input  logic        rx_en_set,
    input  logic        tx_en_set,
    output logic        rx_en,
    output logic        tx_en,
    output logic [31:0] rx_ptr,
    output logic [31:0] tx_ptr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic [2:0]  rx_err,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic [2:0]  tx_err
);
    logic        r_req, r_we, r_ack;
    logic [31:0] r_addr, r_wdata;
    logic        t_req, t_we, t_ack;
    logic [31:0] t_addr, t_wdata;

    bd_ring_rx #(.MAX_FRAME(MAX_FRAME)) u_rx (
        .clk(clk), .rst_n(rst_n), .ptr_wr(rx_ptr_wr), .ptr_wdata(ptr_wdata),
        .en_set(rx_en_set), .en(rx_en), .ptr_cur(rx_ptr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(r_req), .mem_we(r_we), .mem_addr(r_addr), .mem_wdata(r_wdata),
        .mem_ack(r_ack), .mem_rdata(mem_rdata)
    );

    bd_ring_tx u_tx (
        .clk(clk), .rst_n(rst_n), .ptr_wr(tx_ptr_wr), .ptr_wdata(ptr_wdata),
        .en_set(tx_en_set), .en(tx_en), .ptr_cur(tx_ptr),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_err(tx_err),
        .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr), .mem_wdata(t_wdata),
        .mem_ack(t_ack), .mem_rdata(mem_rdata)
    );

    bd_ring_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .a_req(r_req), .a_we(r_we), .a_addr(r_addr), .a_wdata(r_wdata), .a_ack(r_ack),
        .b_req(t_req), .b_we(t_we), .b_addr(t_addr), .b_wdata(t_wdata), .b_ack(t_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    p_ack_needs_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ack || t_ack) |-> mem_req);
endmodule

// File: tb/bd_ring_dma_tb.sv
module bd_ring_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ptr_wr = 0, tx_ptr_wr = 0, rx_en_set = 0, tx_en_set = 0;
    logic [31:0] ptr_wdata = '0;
    logic        rx_en, tx_en, mem_req, mem_we, rx_ready, tx_valid, tx_last;
    logic [31:0] rx_ptr, tx_ptr, mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        rx_valid = 0, rx_last = 0;
    logic [7:0]  rx_data = '0, tx_data;
    logic [2:0]  rx_err = '0, tx_err = '0;
    logic        tx_ready = 1'b1;
    logic        stall = 1'b0;

    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    bd_ring_dma #(.MAX_FRAME(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_ptr_wr(rx_ptr_wr), .tx_ptr_wr(tx_ptr_wr),
        .ptr_wdata(ptr_wdata), .rx_en_set(rx_en_set), .tx_en_set(tx_en_set),
        .rx_en(rx_en), .tx_en(tx_en), .rx_ptr(rx_ptr), .tx_ptr(tx_ptr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .tx_err(tx_err)
    );

    // Memory model: one-cycle ack latency, write log.
    logic [31:0] mem [0:255];
    logic [31:0] wlog [0:63];
    int          wcnt = 0;
    logic        ack_q = 1'b0;
    logic [31:0] rd_q = '0;
    assign mem_ack   = ack_q;
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else begin
            ack_q <= mem_req && !ack_q;
            if (mem_req && !ack_q) rd_q <= mem[mem_addr[9:2]];
            if (mem_req && ack_q && mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wlog[wcnt % 64]    <= mem_addr;
                wcnt               <= wcnt + 1;
            end
        end
    end

    // Transmit sink capture.
    logic [7:0] txb [0:31];
    logic       txl [0:31];
    int         txn = 0;
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            txb[txn % 32] <= tx_data;
            txl[txn % 32] <= tx_last;
            txn           <= txn + 1;
        end
    end
    always @(negedge clk) tx_ready <= stall ? ~tx_ready : 1'b1;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input int a);
        return mem[a/4];
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        mem[a/4] = d;
    endtask

    task automatic set_ptr(input bit is_rx, input logic [31:0] v);
        @(negedge clk);
        ptr_wdata = v;
        if (is_rx) rx_ptr_wr = 1; else tx_ptr_wr = 1;
        @(negedge clk);
        rx_ptr_wr = 0; tx_ptr_wr = 0;
    endtask

    task automatic enable(input bit is_rx);
        @(negedge clk);
        if (is_rx) rx_en_set = 1; else tx_en_set = 1;
        @(negedge clk);
        rx_en_set = 0; tx_en_set = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_stop(input bit is_rx, input string req);
        int n = 0;
        while ((is_rx ? rx_en : tx_en) && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(req, {31'd0, (is_rx ? rx_en : tx_en)}, 32'd0);
    endtask

    task automatic rx_byte(input logic [7:0] d, input bit last, input logic [2:0] e);
        bit took;
        rx_valid = 1; rx_data = d; rx_last = last; rx_err = e;
        forever begin
            took = rx_ready;
            @(negedge clk);
            if (took) break;
        end
        rx_valid = 0; rx_last = 0; rx_err = '0;
    endtask

    task automatic rx_frame(input logic [7:0] first, input int n, input logic [2:0] e);
        for (int i = 0; i < n; i++)
            rx_byte(first + 8'(i), i == n - 1, (i == n - 1) ? e : 3'b000);
    endtask

    task automatic t_reset;
        chk("R1 rx_en", {31'd0, rx_en}, 0);
        chk("R1 tx_en", {31'd0, tx_en}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 rx_ptr", rx_ptr, 0);
    endtask

    task automatic t_ptr;
        set_ptr(0, 32'h0000_0105);
        chk("R2 aligned tx_ptr", tx_ptr, 32'h100);
    endtask

    // Single wrap descriptor: bytes, last flag, writeback, loop to itself.
    task automatic t_tx_single;
        int n0;
        wr(32'h100, 32'h0000_1806); wr(32'h104, 32'h200);
        wr(32'h200, 32'h0403_0201); wr(32'h204, 32'hFFFF_0605);
        n0 = txn;
        enable(0);
        wait_stop(0, "R9 tx stops");
        chk("R3 byte count", txn - n0, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R3 byte", {24'd0, txb[(n0 + i) % 32]}, i + 1);
            chk("R3 last", {31'd0, txl[(n0 + i) % 32]}, (i == 5) ? 1 : 0);
        end
        chk("R4 status", rd(32'h100), 32'h0000_1006);
        chk("R12 loops to itself", tx_ptr, 32'h100);
        chk("R11 last write", wlog[(wcnt - 1) % 64], 32'h100);
    endtask

    // Two descriptors, backpressure and error flags.
    task automatic t_tx_ring;
        int n0;
        logic [7:0] exp [0:7];
        exp = '{8'h11, 8'h22, 8'h33, 8'h55, 8'h66, 8'h77, 8'h88, 8'hA9};
        wr(32'h100, 32'h0000_0803); wr(32'h104, 32'h200);
        wr(32'h108, 32'h0000_1805); wr(32'h10C, 32'h240);
        wr(32'h200, 32'h4433_2211);
        wr(32'h240, 32'h8877_6655); wr(32'h244, 32'h0000_00A9);
        set_ptr(0, 32'h100);
        tx_err = 3'b101; stall = 1'b1;
        n0 = txn;
        enable(0);
        wait_stop(0, "R9 tx ring stops");
        stall = 1'b0; tx_err = '0;
        chk("R3 ring count", txn - n0, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R3 ring byte", {24'd0, txb[(n0 + i) % 32]}, {24'd0, exp[i]});
            chk("R3 ring last", {31'd0, txl[(n0 + i) % 32]}, (i == 2 || i == 7) ? 1 : 0);
        end
        chk("R4 errors desc0", rd(32'h100), 32'h0000_A003);
        chk("R4 errors desc1", rd(32'h108), 32'h0000_B005);
        chk("R8 tx wrap to base", tx_ptr, 32'h100);
    endtask

    task automatic t_rx_basic;
        wr(32'h140, 32'h0000_1800); wr(32'h144, 32'h300);
        for (int a = 32'h300; a < 32'h320; a += 4) wr(a, 32'hDEAD_BEEF);
        set_ptr(1, 32'h140);
        enable(1);
        rx_frame(8'hA0, 6, 3'b000);
        wait_stop(1, "R9 rx stops");
        chk("R5 word0", rd(32'h300), 32'hA3A2_A1A0);
        chk("R5 word1 zero fill", rd(32'h304), 32'h0000_A5A4);
        chk("R5 untouched", rd(32'h308), 32'hDEAD_BEEF);
        chk("R5 status", rd(32'h140), 32'h0000_1006);
        chk("R11 rx last write", wlog[(wcnt - 1) % 64], 32'h140);
        chk("R9 rx ptr held", rx_ptr, 32'h140);
    endtask

    task automatic t_rx_err;
        wr(32'h140, 32'h0000_1800);
        enable(1);
        rx_frame(8'h10, 2, 3'b101);
        wait_stop(1, "R9 rx err stop");
        chk("R6 error bits", rd(32'h140), 32'h0001_5002);
    endtask

    task automatic t_rx_long;
        wr(32'h140, 32'h0000_1800);
        enable(1);
        rx_frame(8'h01, 25, 3'b000);
        wait_stop(1, "R9 rx long stop");
        chk("R7 status", rd(32'h140), 32'h0000_3014);
        chk("R7 last stored word", rd(32'h310), 32'h1413_1211);
        chk("R7 beyond limit untouched", rd(32'h314), 32'hDEAD_BEEF);
    endtask

    task automatic t_rx_drop;
        int w0;
        w0 = wcnt;
        rx_frame(8'h40, 4, 3'b000);
        chk("R10 no writes when disabled", wcnt - w0, 0);
        chk("R10 still disabled", {31'd0, rx_en}, 0);
        wr(32'h140, 32'h0000_1800);
        wr(32'h300, 32'hDEAD_BEEF);
        rx_byte(8'h51, 0, 3'b000);
        rx_byte(8'h52, 0, 3'b000);
        enable(1);
        rx_byte(8'h53, 0, 3'b000);
        rx_byte(8'h54, 1, 3'b000);
        rx_frame(8'h61, 3, 3'b000);
        wait_stop(1, "R9 rx drop stop");
        chk("R10 partial frame skipped", rd(32'h300), 32'h0063_6261);
        chk("R10 status", rd(32'h140), 32'h0000_1003);
    endtask

    task automatic t_rx_ring;
        wr(32'h180, 32'h0000_0800); wr(32'h184, 32'h380);
        wr(32'h188, 32'h0000_1800); wr(32'h18C, 32'h3A0);
        set_ptr(1, 32'h180);
        enable(1);
        rx_frame(8'h71, 1, 3'b000);
        rx_frame(8'h81, 2, 3'b000);
        wait_stop(1, "R9 ring stop");
        chk("R8 desc0 status", rd(32'h180), 32'h0000_0001);
        chk("R8 desc1 status", rd(32'h188), 32'h0000_1002);
        chk("R8 desc0 data", rd(32'h380), 32'h0000_0071);
        chk("R8 desc1 data", rd(32'h3A0), 32'h0000_8281);
        chk("R8 rx wrap to base", rx_ptr, 32'h180);
        wr(32'h180, 32'h0000_0800);
        enable(1);
        rx_frame(8'h91, 1, 3'b000);
        wait_stop(1, "R9 resume stop");
        chk("R9 resumed data", rd(32'h380), 32'h0000_0091);
        chk("R9 stopped on next", rx_ptr, 32'h188);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr();
        t_tx_single();
        t_tx_ring();
        t_rx_basic();
        t_rx_err();
        t_rx_long();
        t_rx_drop();
        t_rx_ring();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule